// File: doc/BRIEF.md
# Stereo SAD Disparity Matcher

This block estimates per-pixel disparity between a left (template) and a right (search) grayscale image stream. For each output pixel it compares a 5x5 template window with sixteen search windows, each offset horizontally by one candidate disparity. It scores every candidate with a sum of absolute differences (SAD) and reduces the sixteen scores through a pipelined tree of clocked minimum comparators. The winning offset is the disparity. A larger disparity means a closer object.

Both images arrive in raster order, two horizontally adjacent pixels per beat. Each stream has its own write strobe. The block keeps one pending beat per stream. A processing step happens as soon as both streams have delivered the beat for the current position, whether they arrive together or one after the other. If a stream writes a second time before its partner arrives, the newer beat replaces the held one. Four line buffers per image supply the window rows, and shift registers of window columns supply the horizontal span. The datapath is fully pipelined and accepts one step per clock. Every step yields two results at once.

Top module: `stereo_sad_matcher`

## Requirements
- R1: The SAD of a candidate is the sum of the 25 absolute differences between 8-bit pixels of the 5x5 template window and the 5x5 search window; the winning value appears on `sad_o`.
- R2: Candidate d (0 to 15) compares the template window centred at (cx, cy) with the search window centred at (cx-d, cy); `disp_o` carries the d of the smallest SAD.
- R3: When several candidates share the smallest SAD, the lowest d is reported.
- R4: Bits [7:0] of a beat are the even column x=2b and bits [15:8] the odd column x=2b+1. Lane p results are on `disp_o[4p+3:4p]`, `sad_o[13p+12:13p]` and `border_o[p]`.
- R5: A step is taken when both streams have delivered the beat for the current position, in the same cycle or in either order with idle cycles between. Positions advance in raster order and wrap at the row and frame ends.
- R6: A step on the beat at row y, column x reports, for each lane, the window centred at (x-2, y-2). `done_o` is high for one cycle, exactly five clock edges after the edge that took the step. Steps may follow on every cycle.
- R7: If y < 4 or x < 19 (window or search range off the image), the lane reports `border_o`=1, disparity 0 and SAD 0.
- R8: While `done_o` is low, `disp_o`, `sad_o` and `border_o` are all zero.
- R9: Reset clears the pipeline valid bits and any held partial beat. No result appears for a step taken before reset, and a beat held before reset never pairs with one written after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmpl_wr_i | input | 1 | Template beat write strobe |
| tmpl_pix_i | input | 16 | Two template pixels |
| srch_wr_i | input | 1 | Search beat write strobe |
| srch_pix_i | input | 16 | Two search pixels |
| done_o | output | 1 | Results valid for one cycle |
| disp_o | output | 8 | Disparity per lane |
| sad_o | output | 26 | Winning SAD per lane |
| border_o | output | 2 | Border (invalid) flag per lane |

## Verification
A fault in the comparator tree or in the tie handling shows up as a wrong `disp_o` on the very result that passes through it. That result arrives five edges after its step. A fault in the column shift registers or line buffers corrupts `sad_o` for every non-border pixel from the first window that spans the bad column or row. A stale pending beat or a leftover valid bit after reset shows up as an extra or misplaced `done_o` pulse. Because each result's arrival cycle is checked against its step, any change in pipeline depth is caught on the first result.

// File: rtl/sad_pkg.sv
package sad_pkg;

   // Bits needed for the sum of win*win absolute differences of pw-bit pixels.
   function automatic int sad_bits(input int win, input int pw);
      return $clog2(win * win * ((1 << pw) - 1) + 1);
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sad_line_buf.sv
module sad_line_buf #(
   parameter int BEAT_W = 16,
   parameter int ROWS   = 4,
   parameter int DEPTH  = 160,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   we_i,
   input  logic [AW-1:0]          addr_i,
   input  logic [BEAT_W-1:0]      wdata_i,
   output logic [ROWS*BEAT_W-1:0] rows_o   // slot k holds row y-1-k
);

   logic [BEAT_W-1:0] mem [ROWS][DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) begin
         mem[0][addr_i] <= wdata_i;
         for (int k = 1; k < ROWS; k++) begin
            mem[k][addr_i] <= mem[k-1][addr_i];
         end
      end
   end

   for (genvar k = 0; k < ROWS; k++) begin : g_rd
      assign rows_o[k*BEAT_W +: BEAT_W] = mem[k][addr_i];
   end

endmodule

// File: rtl/sad_unit.sv
module sad_unit #(
   parameter int PIX_W = 8,
   parameter int WIN   = 5,
   parameter int SAD_W = 13,
   localparam int NPIX = WIN * WIN,
   localparam int MAX_SAD = NPIX * ((1 << PIX_W) - 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [NPIX*PIX_W-1:0] tmpl_i,
   input  logic [NPIX*PIX_W-1:0] srch_i,
   output logic                  done_o,
   output logic [SAD_W-1:0]      sad_o
);

   logic [SAD_W-1:0] acc;

   always_comb begin
      acc = '0;
      for (int i = 0; i < NPIX; i++) begin
         if (tmpl_i[i*PIX_W +: PIX_W] > srch_i[i*PIX_W +: PIX_W])
            acc = acc + SAD_W'(tmpl_i[i*PIX_W +: PIX_W] - srch_i[i*PIX_W +: PIX_W]);
         else
            acc = acc + SAD_W'(srch_i[i*PIX_W +: PIX_W] - tmpl_i[i*PIX_W +: PIX_W]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o <= 1'b0;
         sad_o  <= '0;
      end else begin
         done_o <= start_i;
         if (start_i) sad_o <= acc;
      end
   end

   AST_SAD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (int'(sad_o) <= MAX_SAD)); // R1

endmodule

// File: rtl/sad_min_cmp.sv
module sad_min_cmp #(
   parameter int SAD_W  = 13,
   parameter int DISP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic [SAD_W-1:0]  sad0_i,
   input  logic [DISP_W-1:0] pos0_i,
   input  logic [SAD_W-1:0]  sad1_i,
   input  logic [DISP_W-1:0] pos1_i,
   output logic              vld_o,
   output logic [SAD_W-1:0]  sad_o,
   output logic [DISP_W-1:0] pos_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         sad_o <= '0;
         pos_o <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            if (sad1_i < sad0_i) begin
               sad_o <= sad1_i;
               pos_o <= pos1_i;
            end else begin
               sad_o <= sad0_i;
               pos_o <= pos0_i;
            end
         end
      end
   end

   AST_MIN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      vld_i |=> (sad_o <= $past(sad0_i)) && (sad_o <= $past(sad1_i))); // R2

   AST_TIE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && (sad0_i == sad1_i)) |=> (pos_o == $past(pos0_i))); // R3

endmodule

// File: rtl/sad_min_tree.sv
module sad_min_tree #(
   parameter int N      = 16,
   parameter int SAD_W  = 13,
   localparam int DISP_W = $clog2(N),
   localparam int LEVELS = $clog2(N)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vld_i,
   input  logic [N*SAD_W-1:0] sad_i,   // candidate d at slot d
   output logic               vld_o,
   output logic [SAD_W-1:0]   sad_o,
   output logic [DISP_W-1:0]  pos_o
);

   for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
      localparam int NODES = N >> l;
      logic [NODES*SAD_W-1:0]  s;
      logic [NODES*DISP_W-1:0] p;
      logic [NODES-1:0]        v;

      if (l == 0) begin : g_leaf
         assign s = sad_i;
         assign v = {NODES{vld_i}};
         for (genvar n = 0; n < NODES; n++) begin : g_idx
            assign p[n*DISP_W +: DISP_W] = DISP_W'(n);
         end
      end else begin : g_node
         for (genvar n = 0; n < NODES; n++) begin : g_cmp
            sad_min_cmp #(.SAD_W(SAD_W), .DISP_W(DISP_W)) u_cmp (
               .clk   (clk),
               .rst_n (rst_n),
               .vld_i (g_lvl[l-1].v[2*n] & g_lvl[l-1].v[2*n+1]),
               .sad0_i(g_lvl[l-1].s[(2*n)*SAD_W +: SAD_W]),
               .pos0_i(g_lvl[l-1].p[(2*n)*DISP_W +: DISP_W]),
               .sad1_i(g_lvl[l-1].s[(2*n+1)*SAD_W +: SAD_W]),
               .pos1_i(g_lvl[l-1].p[(2*n+1)*DISP_W +: DISP_W]),
               .vld_o (v[n]),
               .sad_o (s[n*SAD_W +: SAD_W]),
               .pos_o (p[n*DISP_W +: DISP_W])
            );
         end
      end
   end

   assign vld_o = g_lvl[LEVELS].v[0];
   assign sad_o = g_lvl[LEVELS].s;
   assign pos_o = g_lvl[LEVELS].p;

endmodule

// File: rtl/stereo_sad_matcher.sv
module stereo_sad_matcher #(
   parameter int PIX_W = 8,
   parameter int WIN   = 5,
   parameter int NDISP = 16,
   parameter int PAR   = 2,
   parameter int IMG_W = 320,
   parameter int IMG_H = 240,
   localparam int BEAT_W = PAR * PIX_W,
   localparam int SAD_W  = sad_pkg::sad_bits(WIN, PIX_W),
   localparam int DISP_W = $clog2(NDISP)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tmpl_wr_i,
   input  logic [BEAT_W-1:0]     tmpl_pix_i,
   input  logic                  srch_wr_i,
   input  logic [BEAT_W-1:0]     srch_pix_i,
   output logic                  done_o,
   output logic [PAR*DISP_W-1:0] disp_o,
   output logic [PAR*SAD_W-1:0]  sad_o,
   output logic [PAR-1:0]        border_o
);

   localparam int BEATS  = IMG_W / PAR;
   localparam int BX_W   = $clog2(BEATS);
   localparam int Y_W    = $clog2(IMG_H);
   localparam int ROWS   = WIN - 1;
   localparam int COL_W  = WIN * PIX_W;
   localparam int NT     = WIN + PAR - 1;
   localparam int NS     = WIN + NDISP - 1 + PAR - 1;
   localparam int LEVELS = $clog2(NDISP);
   localparam int MIN_X  = WIN - 1 + NDISP - 1;
   localparam int MIN_Y  = WIN - 1;
   localparam int IF_W   = $clog2(LEVELS + 3) + 1;

   // elaboration-time parameter checks
   if (!sad_pkg::is_pow2(NDISP)) begin : g_chk_ndisp
      $error("NDISP must be a power of two");
   end
   if ((WIN < 3) || (WIN % 2 == 0)) begin : g_chk_win
      $error("WIN must be odd and at least 3");
   end
   if ((IMG_W % PAR != 0) || (BEATS < 2)) begin : g_chk_w
      $error("IMG_W must be a multiple of PAR with at least two beats");
   end
   if (IMG_H < WIN) begin : g_chk_h
      $error("IMG_H must cover the window");
   end

   // ---------------- pairing of the two streams ----------------
   logic              t_have, s_have;
   logic [BEAT_W-1:0] t_hold, s_hold, t_cur, s_cur;
   logic              step;

   assign t_cur = tmpl_wr_i ? tmpl_pix_i : t_hold;
   assign s_cur = srch_wr_i ? srch_pix_i : s_hold;
   assign step  = (t_have | tmpl_wr_i) & (s_have | srch_wr_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         t_have <= 1'b0;
         s_have <= 1'b0;
         t_hold <= '0;
         s_hold <= '0;
      end else begin
         if (step)           t_have <= 1'b0;
         else if (tmpl_wr_i) t_have <= 1'b1;
         if (step)           s_have <= 1'b0;
         else if (srch_wr_i) s_have <= 1'b1;
         if (tmpl_wr_i) t_hold <= tmpl_pix_i;
         if (srch_wr_i) s_hold <= srch_pix_i;
      end
   end

   // ---------------- position counters ----------------
   logic [BX_W-1:0] bx;
   logic [Y_W-1:0]  ry;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bx <= '0;
         ry <= '0;
      end else if (step) begin
         if (bx == BX_W'(BEATS - 1)) begin
            bx <= '0;
            ry <= (ry == Y_W'(IMG_H - 1)) ? '0 : ry + 1'b1;
         end else begin
            bx <= bx + 1'b1;
         end
      end
   end

   // ---------------- line buffers ----------------
   logic [ROWS*BEAT_W-1:0] t_rows, s_rows;

   sad_line_buf #(.BEAT_W(BEAT_W), .ROWS(ROWS), .DEPTH(BEATS)) u_tmpl_lb (
      .clk(clk), .we_i(step), .addr_i(bx), .wdata_i(t_cur), .rows_o(t_rows));

   sad_line_buf #(.BEAT_W(BEAT_W), .ROWS(ROWS), .DEPTH(BEATS)) u_srch_lb (
      .clk(clk), .we_i(step), .addr_i(bx), .wdata_i(s_cur), .rows_o(s_rows));

   // new columns: pixel r is row y-ROWS+r, the current pixel last
   logic [COL_W-1:0] t_new [PAR];
   logic [COL_W-1:0] s_new [PAR];

   always_comb begin
      for (int p = 0; p < PAR; p++) begin
         for (int r = 0; r < WIN; r++) begin
            if (r < ROWS) begin
               t_new[p][r*PIX_W +: PIX_W] = t_rows[(ROWS-1-r)*BEAT_W + p*PIX_W +: PIX_W];
               s_new[p][r*PIX_W +: PIX_W] = s_rows[(ROWS-1-r)*BEAT_W + p*PIX_W +: PIX_W];
            end else begin
               t_new[p][r*PIX_W +: PIX_W] = t_cur[p*PIX_W +: PIX_W];
               s_new[p][r*PIX_W +: PIX_W] = s_cur[p*PIX_W +: PIX_W];
            end
         end
      end
   end

   // ---------------- column windows (index 0 = oldest) ----------------
   logic [COL_W-1:0] tcol [NT];
   logic [COL_W-1:0] scol [NS];

   always_ff @(posedge clk) begin
      if (step) begin
         for (int i = 0; i < NT - PAR; i++) tcol[i] <= tcol[i+PAR];
         for (int i = 0; i < NS - PAR; i++) scol[i] <= scol[i+PAR];
         for (int p = 0; p < PAR; p++) begin
            tcol[NT-PAR+p] <= t_new[p];
            scol[NS-PAR+p] <= s_new[p];
         end
      end
   end

   // ---------------- step metadata ----------------
   logic           step_q;
   logic [PAR-1:0] border_q;
   logic [PAR-1:0] brd [LEVELS+1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q   <= 1'b0;
         border_q <= '0;
         for (int i = 0; i <= LEVELS; i++) brd[i] <= '0;
      end else begin
         step_q <= step;
         if (step) begin
            for (int p = 0; p < PAR; p++) begin
               border_q[p] <= (int'(ry) < MIN_Y) || ((int'(bx) * PAR + p) < MIN_X);
            end
         end
         brd[0] <= border_q;
         for (int i = 1; i <= LEVELS; i++) brd[i] <= brd[i-1];
      end
   end

   // ---------------- SAD units and reduction per lane ----------------
   logic [PAR-1:0]    tree_vld;
   logic [SAD_W-1:0]  tree_sad [PAR];
   logic [DISP_W-1:0] tree_pos [PAR];

   for (genvar p = 0; p < PAR; p++) begin : g_lane
      logic [NDISP*SAD_W-1:0] sad_vec;
      logic [NDISP-1:0]       sad_done;

      for (genvar d = 0; d < NDISP; d++) begin : g_cand
         localparam int S0 = NS - PAR + p - WIN + 1 - d;
         logic [WIN*COL_W-1:0] tw, sw;
         for (genvar c = 0; c < WIN; c++) begin : g_col
            assign tw[c*COL_W +: COL_W] = tcol[p + c];
            assign sw[c*COL_W +: COL_W] = scol[S0 + c];
         end
         sad_unit #(.PIX_W(PIX_W), .WIN(WIN), .SAD_W(SAD_W)) u_sad (
            .clk(clk), .rst_n(rst_n), .start_i(step_q),
            .tmpl_i(tw), .srch_i(sw),
            .done_o(sad_done[d]), .sad_o(sad_vec[d*SAD_W +: SAD_W]));
      end

      sad_min_tree #(.N(NDISP), .SAD_W(SAD_W)) u_tree (
         .clk(clk), .rst_n(rst_n), .vld_i(&sad_done), .sad_i(sad_vec),
         .vld_o(tree_vld[p]), .sad_o(tree_sad[p]), .pos_o(tree_pos[p]));

      assign disp_o[p*DISP_W +: DISP_W] = (done_o && !brd[LEVELS][p]) ? tree_pos[p] : '0;
      assign sad_o[p*SAD_W +: SAD_W]    = (done_o && !brd[LEVELS][p]) ? tree_sad[p] : '0;
      assign border_o[p]                = done_o & brd[LEVELS][p];
   end

   assign done_o = &tree_vld;

   // ---------------- in-flight tracking for the checks ----------------
   logic [IF_W-1:0] inflight;

   always_ff @(posedge clk) begin
      if (!rst_n) inflight <= '0;
      else if (step && !done_o) inflight <= inflight + 1'b1;
      else if (!step && done_o) inflight <= inflight - 1'b1;
   end

   AST_DONE_HAS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (inflight != '0)); // R9

   AST_BORDER_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !border_o[0]) |-> !border_o[PAR-1]); // R7

endmodule

// File: tb/stereo_sad_matcher_tb.sv
module stereo_sad_matcher_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W = 32, H = 8, ND = 16, SW = 13, DW = 4;
   localparam int QD = 1024;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        twr = 1'b0, swr = 1'b0;
   logic [15:0] tpix = '0, spix = '0;
   logic        done_o;
   logic [7:0]  disp_o;
   logic [25:0] sad_o;
   logic [1:0]  border_o;

   stereo_sad_matcher #(.IMG_W(W), .IMG_H(H)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .tmpl_wr_i(twr), .tmpl_pix_i(tpix),
      .srch_wr_i(swr), .srch_pix_i(spix),
      .done_o(done_o), .disp_o(disp_o), .sad_o(sad_o), .border_o(border_o));

   always #(CLK_PERIOD/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int timg [H][W];
   int simg [H][W];
   int checks = 0, errors = 0, done_cnt = 0;
   int q_d [2][QD];
   int q_s [2][QD];
   int q_b [2][QD];
   int q_c [QD];
   int wr_ptr = 0, rd_ptr = 0, idx = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // reference: border rule (R7), exhaustive SAD (R1), lowest-index minimum (R2, R3)
   task automatic model(input int x, input int y, output int d, output int s, output int b);
      int best, bd, acc;
      if (y < 4 || x < 19) begin
         d = 0; s = 0; b = 1;
      end else begin
         best = 1 << 30; bd = 0;
         for (int k = 0; k < ND; k++) begin
            acc = 0;
            for (int dy = 0; dy < 5; dy++)
               for (int dx = 0; dx < 5; dx++) begin
                  int a, c;
                  a = timg[y-4+dy][x-4+dx];
                  c = simg[y-4+dy][x-4+dx-k];
                  acc += (a > c) ? a - c : c - a;
               end
            if (acc < best) begin best = acc; bd = k; end
         end
         d = bd; s = best; b = 0;
      end
   endtask

   // called at the negedge where the pairing beat is driven (R6: result after 5 more edges)
   task automatic push(input int b, input int y);
      int d, s, f;
      for (int p = 0; p < 2; p++) begin
         model(2*b + p, y - 2 + 2, d, s, f);
         q_d[p][wr_ptr % QD] = d;
         q_s[p][wr_ptr % QD] = s;
         q_b[p][wr_ptr % QD] = f;
      end
      q_c[wr_ptr % QD] = cyc + 6;
      wr_ptr++;
   endtask

   task automatic set_data(input int b, input int y);
      tpix = {8'(timg[y][2*b+1]), 8'(timg[y][2*b])};   // R4 lane order
      spix = {8'(simg[y][2*b+1]), 8'(simg[y][2*b])};
   endtask

   // mode 0: both strobes together; 1: template first; 2: search first; 3: template, gap, search (R5)
   task automatic beat(input int mode, input int b, input int y);
      @(negedge clk);
      set_data(b, y);
      case (mode)
         0: begin twr = 1; swr = 1; end
         1: begin twr = 1; swr = 0; @(negedge clk); twr = 0; swr = 1; end
         2: begin twr = 0; swr = 1; @(negedge clk); twr = 1; swr = 0; end
         default: begin
            twr = 1; swr = 0; @(negedge clk); twr = 0;
            @(negedge clk); swr = 1;
         end
      endcase
      push(b, y);
   endtask

   task automatic drain(input string req);
      @(negedge clk); twr = 0; swr = 0;
      repeat (10) @(negedge clk);
      check(rd_ptr == wr_ptr, req, "results outstanding", wr_ptr - rd_ptr, 0);
   endtask

   task automatic send_frame(input int mode);
      for (int y = 0; y < H; y++)
         for (int b = 0; b < W/2; b++)
            beat(mode, b, y);
      drain("R5");
   endtask

   // output monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (done_o) begin
            done_cnt++;
            if (rd_ptr == wr_ptr) begin
               check(1'b0, "R9", "unexpected done", 1, 0);
            end else begin
               idx = rd_ptr % QD;
               check(cyc == q_c[idx], "R6", "result cycle", cyc, q_c[idx]);
               for (int p = 0; p < 2; p++) begin
                  check(int'(disp_o[p*DW +: DW]) == q_d[p][idx], "R2", "disparity",
                        int'(disp_o[p*DW +: DW]), q_d[p][idx]);
                  check(int'(sad_o[p*SW +: SW]) == q_s[p][idx], "R1", "sad",
                        int'(sad_o[p*SW +: SW]), q_s[p][idx]);
                  check(int'(border_o[p]) == q_b[p][idx], "R7", "border",
                        int'(border_o[p]), q_b[p][idx]);
               end
               rd_ptr++;
            end
         end else begin
            check((disp_o == '0) && (sad_o == '0) && (border_o == '0), "R8",
                  "idle outputs", int'(sad_o), 0);
         end
      end
   end

   // scenario table: true shift, pairing mode (R5), image seed
   localparam int NSCN = 6;
   localparam int SCN [NSCN][3] = '{
      '{3, 0, 11}, '{11, 1, 57}, '{0, 2, 200}, '{15, 0, 5}, '{7, 3, 99}, '{9, 0, 143}};

   task automatic fill(input int shift, input int seed);
      for (int y = 0; y < H; y++)
         for (int x = 0; x < W; x++)
            timg[y][x] = (x*x*7 + y*53 + x*29 + seed*3 + (x ^ y)*11) % 256;
      for (int y = 0; y < H; y++)
         for (int x = 0; x < W; x++)
            simg[y][x] = (x + shift < W) ? timg[y][x+shift] : (x*17 + y + seed) % 256;
   endtask

   int dc0;

   initial begin
      // reset state (R9, R8)
      repeat (3) @(negedge clk);
      check(done_o == 1'b0, "R9", "done in reset", int'(done_o), 0);
      check((disp_o == '0) && (sad_o == '0) && (border_o == '0), "R8",
            "outputs in reset", int'(sad_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // table walk: R1, R2, R4, R5, R6, R7
      for (int i = 0; i < NSCN; i++) begin
         fill(SCN[i][0], SCN[i][2]);
         send_frame(SCN[i][1]);
      end

      // R3: period-8 texture shifted by 5 ties d=5 with d=13; lower index expected
      for (int y = 0; y < H; y++)
         for (int x = 0; x < W; x++) begin
            timg[y][x] = ((x % 8) * 30 + y * 7) % 256;
            simg[y][x] = (((x + 5) % 8) * 30 + y * 7) % 256;
         end
      send_frame(0);

      // R9: a held template beat does not survive reset
      @(negedge clk); set_data(0, 0); twr = 1;
      @(negedge clk); twr = 0; rst_n = 0;
      @(negedge clk); rst_n = 1;
      dc0 = done_cnt;
      @(negedge clk); swr = 1;
      @(negedge clk); swr = 0;
      repeat (10) @(negedge clk);
      check(done_cnt == dc0, "R9", "pairing across reset", done_cnt - dc0, 0);
      @(negedge clk); twr = 1; push(0, 0);      // now pairs, position 0 is border
      drain("R9");

      // R9: results in flight are dropped by reset
      rst_n = 0; @(negedge clk); rst_n = 1;
      for (int b = 0; b < 3; b++) beat(0, b, 0);
      @(negedge clk); twr = 0; swr = 0; rst_n = 0;
      rd_ptr = wr_ptr;
      dc0 = done_cnt;
      @(negedge clk); rst_n = 1;
      repeat (10) @(negedge clk);
      check(done_cnt == dc0, "R9", "in-flight after reset", done_cnt - dc0, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule